// File: doc/BRIEF.md
# DRAM ECC error log

This block keeps the record of memory error events so that software can inspect them at leisure. The memory datapath raises single-cycle strobes for five events: a correctable ECC error, an uncorrectable ECC error, a refresh timeout, a locked access that targets non-DRAM memory, and a thermal sensor trip. Each event sets a sticky status bit. An ECC event also presents the failing physical address, the channel it came from and its 8-bit syndrome.

Only one address, channel and syndrome set is held. An uncorrectable error may replace a held correctable record. A held uncorrectable record stays fixed until software clears its status bit. Software reads the status, then the captured record, then the status again. A changed uncorrectable bit between the two status reads shows that the record was replaced mid-read.

A small register port selects one of five registers. Software clears status bits by writing ones to them and sets per-event enables in a command register. A one-cycle system-error pulse marks each enabled event that newly sets its status bit.

Top module: `ecc_err_log`

## Requirements
- R1: The status register (select code 0) sets bit 0 for a correctable error, bit 1 for an uncorrectable error, bit 8 for a refresh timeout, bit 9 for a locked non-DRAM access and bit 11 for a thermal event. All other bits of the 32-bit read value are 0. Bits set one clock edge after the strobe.
- R2: Writing status with a 1 in an active bit clears that bit. A 0 leaves the bit unchanged.
- R3: If an event strobe and a software clear hit the same status bit in one cycle, the bit ends up set.
- R4: A correctable error taken while no ECC error is logged captures the record. The address pointer (select code 2) shows address bits 31:7 in bits 31:7, zeros in bits 6:1 and the channel in bit 0. The extended address (select code 3) shows address bit 32 in bit 0. The syndrome register (select code 4) shows the syndrome in bits 7:0.
- R5: A correctable error that arrives while a correctable error is already logged leaves the captured record unchanged.
- R6: An uncorrectable error that arrives while none is logged captures its own address, channel and syndrome. This holds whether or not a correctable record is held, and when both error kinds strobe in the same cycle.
- R7: While an uncorrectable error is logged, the captured record does not change. Capture is gated by the logged state held at the start of the cycle, so the record stays fixed until the status bit has been cleared.
- R8: The command register (select code 1) is written directly. Only bits 0, 1, 8, 9 and 11 are kept, and the other bits read 0.
- R9: The system-error output is high for exactly the cycle in which a status bit first reads 1 after having read 0, provided that bit's command enable was 1 when the event arrived. A strobe for an already-set bit gives no pulse.
- R10: After reset every register reads 0 and the system-error output is 0.
- R11: Writes to select codes 2, 3 and 4 have no effect on the captured record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ce_i | input | 1 | Correctable ECC error strobe |
| ev_ue_i | input | 1 | Uncorrectable ECC error strobe |
| ev_refresh_to_i | input | 1 | Refresh timeout strobe |
| ev_lock_i | input | 1 | Locked access to non-DRAM memory strobe |
| ev_thermal_i | input | 1 | Thermal sensor event strobe |
| err_addr_i | input | 33 | Failing physical address of the ECC event |
| err_chan_i | input | 1 | Channel of the ECC event |
| err_syn_i | input | 8 | ECC syndrome of the event |
| reg_sel_i | input | 3 | Register select: 0 status, 1 command, 2 address pointer, 3 extended address, 4 syndrome |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register, combinational |
| serr_o | output | 1 | System-error pulse |

## Verification
Read data is combinational, so a register shows its state in the same cycle it is selected. Status, capture, command and system-error results all change at the first clock edge after the strobe or write that causes them. The bench drives every input on the falling edge. It compares the selected register and the system-error output against its reference model shortly after that edge, which is before the rising edge that consumes the new inputs. The model then advances once per rising edge, so every result is checked in the first cycle it is due, and in each cycle after that.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;

    localparam int NUM_EV = 5;
    localparam int STS_W  = 16;

    // event index order used on the internal event vector
    localparam int EV_CE      = 0;
    localparam int EV_UE      = 1;
    localparam int EV_REFRESH = 2;
    localparam int EV_LOCK    = 3;
    localparam int EV_THERMAL = 4;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_CMD    = 3'd1,
        SEL_PTR    = 3'd2,
        SEL_EXT    = 3'd3,
        SEL_SYN    = 3'd4
    } reg_sel_e;

    // status bit position of each event
    function automatic int ev_pos(input int idx);
        case (idx)
            EV_CE:      return 0;
            EV_UE:      return 1;
            EV_REFRESH: return 8;
            EV_LOCK:    return 9;
            EV_THERMAL: return 11;
            default:    return -1;
        endcase
    endfunction

    // event index feeding a status bit, -1 for reserved bits
    function automatic int ev_index(input int bit_pos);
        int r;
        r = -1;
        for (int i = 0; i < NUM_EV; i++) begin
            if (ev_pos(i) == bit_pos) r = i;
        end
        return r;
    endfunction

    function automatic logic [STS_W-1:0] active_mask();
        logic [STS_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_EV; i++) m[ev_pos(i)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ecc_err_status.sv
module ecc_err_status
    import ecc_err_log_pkg::*;
#(
    parameter int W  = STS_W,
    parameter int NE = NUM_EV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] ev_vec,
    input  logic          clr_en,
    input  logic [W-1:0]  clr_bits,
    input  logic          cmd_wr,
    input  logic [W-1:0]  cmd_bits,
    output logic [W-1:0]  sts_q,
    output logic [W-1:0]  cmd_q,
    output logic          serr_q
);

    localparam logic [W-1:0] MASK = W'(active_mask());

    typedef struct packed {
        logic [W-1:0] sts;
        logic [W-1:0] cmd;
        logic         serr;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] set_vec;

    // map each event strobe onto its status bit; reserved bits stay 0
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (ev_index(b) >= 0) begin : g_act
            assign set_vec[b] = ev_vec[ev_index(b)];
        end else begin : g_rsv
            assign set_vec[b] = 1'b0;
        end
    end

    always_comb begin
        logic [W-1:0] clr;
        logic [W-1:0] rise;
        st_d = st_q;
        clr  = clr_en ? (clr_bits & MASK) : '0;
        // set dominates a clear of the same bit
        st_d.sts  = (st_q.sts & ~clr) | set_vec;
        rise      = st_d.sts & ~st_q.sts;
        st_d.serr = |(rise & st_q.cmd);
        if (cmd_wr) st_d.cmd = cmd_bits & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_q  = st_q.sts;
    assign cmd_q  = st_q.cmd;
    assign serr_q = st_q.serr;

    assert_clear_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_bits[0] && !ev_vec[EV_CE]) |=> !sts_q[0]);

    assert_clear_ue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_bits[1] && !ev_vec[EV_UE]) |=> !sts_q[1]);

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vec[EV_THERMAL] |=> sts_q[11]);

    assert_serr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        serr_q |-> ((sts_q & ~$past(sts_q) & $past(cmd_q)) != '0));

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce,
    input  logic                       ue,
    input  logic                       ce_logged,
    input  logic                       ue_logged,
    input  logic [ADDR_W-1:GRAIN_LSB]  addr,
    input  logic                       chan,
    input  logic [SYN_W-1:0]           syn,
    output logic [ADDR_W-1:GRAIN_LSB]  cap_addr_q,
    output logic                       cap_chan_q,
    output logic [SYN_W-1:0]           cap_syn_q
);

    typedef struct packed {
        logic [ADDR_W-1:GRAIN_LSB] addr;
        logic                      chan;
        logic [SYN_W-1:0]          syn;
    } rec_t;

    rec_t rec_d, rec_q;
    logic take_ue, take_ce;

    always_comb begin
        // an uncorrectable record is never replaced; a correctable one only by uncorrectable
        take_ue = ue && !ue_logged;
        take_ce = ce && !ce_logged && !ue_logged;
        rec_d   = rec_q;
        if (take_ue || take_ce) begin
            rec_d.addr = addr;
            rec_d.chan = chan;
            rec_d.syn  = syn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign cap_addr_q = rec_q.addr;
    assign cap_chan_q = rec_q.chan;
    assign cap_syn_q  = rec_q.syn;

    assert_ce_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_logged && !ue) |=> ($stable(cap_addr_q) && $stable(cap_syn_q) && $stable(cap_chan_q)));

    assert_ue_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ue_logged |=> ($stable(cap_addr_q) && $stable(cap_syn_q) && $stable(cap_chan_q)));

    assert_ue_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ue && !ue_logged) |=> (cap_syn_q == $past(syn)));

endmodule

// File: rtl/ecc_err_regif.sv
module ecc_err_regif
    import ecc_err_log_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8,
    parameter int W         = STS_W
) (
    input  logic [2:0]                 sel,
    input  logic                       wr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [W-1:0]               sts,
    input  logic [W-1:0]               cmd,
    input  logic [ADDR_W-1:GRAIN_LSB]  cap_addr,
    input  logic                       cap_chan,
    input  logic [SYN_W-1:0]           cap_syn,
    output logic [DATA_W-1:0]          rdata,
    output logic                       clr_en,
    output logic [W-1:0]               clr_bits,
    output logic                       cmd_wr,
    output logic [W-1:0]               cmd_bits
);

    localparam int EXT_W = ADDR_W - DATA_W;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:W];

    // write decode: status is write-one-to-clear, command is plain write
    always_comb begin
        clr_en   = wr && (reg_sel_e'(sel) == SEL_STATUS);
        cmd_wr   = wr && (reg_sel_e'(sel) == SEL_CMD);
        clr_bits = wdata[W-1:0];
        cmd_bits = wdata[W-1:0];
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_STATUS: rdata[W-1:0] = sts;
            SEL_CMD:    rdata[W-1:0] = cmd;
            SEL_PTR: begin
                rdata[DATA_W-1:GRAIN_LSB] = cap_addr[DATA_W-1:GRAIN_LSB];
                rdata[0]                  = cap_chan;
            end
            SEL_EXT:    rdata[EXT_W-1:0] = cap_addr[ADDR_W-1:DATA_W];
            SEL_SYN:    rdata[SYN_W-1:0] = cap_syn;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_err_log_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ce_i,
    input  logic              ev_ue_i,
    input  logic              ev_refresh_to_i,
    input  logic              ev_lock_i,
    input  logic              ev_thermal_i,
    input  logic [ADDR_W-1:0] err_addr_i,
    input  logic              err_chan_i,
    input  logic [SYN_W-1:0]  err_syn_i,
    input  logic [2:0]        reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              serr_o
);

    logic [NUM_EV-1:0]          ev_vec;
    logic [STS_W-1:0]           sts_q, cmd_q, clr_bits, cmd_bits;
    logic                       clr_en, cmd_wr;
    logic [ADDR_W-1:GRAIN_LSB]  cap_addr;
    logic                       cap_chan;
    logic [SYN_W-1:0]           cap_syn;
    logic                       unused_addr_lo;

    assign unused_addr_lo = ^err_addr_i[GRAIN_LSB-1:0];

    always_comb begin
        ev_vec             = '0;
        ev_vec[EV_CE]      = ev_ce_i;
        ev_vec[EV_UE]      = ev_ue_i;
        ev_vec[EV_REFRESH] = ev_refresh_to_i;
        ev_vec[EV_LOCK]    = ev_lock_i;
        ev_vec[EV_THERMAL] = ev_thermal_i;
    end

    ecc_err_status #(.W(STS_W), .NE(NUM_EV)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_vec   (ev_vec),
        .clr_en   (clr_en),
        .clr_bits (clr_bits),
        .cmd_wr   (cmd_wr),
        .cmd_bits (cmd_bits),
        .sts_q    (sts_q),
        .cmd_q    (cmd_q),
        .serr_q   (serr_o)
    );

    ecc_err_capture #(.ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB), .SYN_W(SYN_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce         (ev_ce_i),
        .ue         (ev_ue_i),
        .ce_logged  (sts_q[ev_pos(EV_CE)]),
        .ue_logged  (sts_q[ev_pos(EV_UE)]),
        .addr       (err_addr_i[ADDR_W-1:GRAIN_LSB]),
        .chan       (err_chan_i),
        .syn        (err_syn_i),
        .cap_addr_q (cap_addr),
        .cap_chan_q (cap_chan),
        .cap_syn_q  (cap_syn)
    );

    ecc_err_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB),
                    .SYN_W(SYN_W), .W(STS_W)) u_regif (
        .sel      (reg_sel_i),
        .wr       (reg_wr_i),
        .wdata    (reg_wdata_i),
        .sts      (sts_q),
        .cmd      (cmd_q),
        .cap_addr (cap_addr),
        .cap_chan (cap_chan),
        .cap_syn  (cap_syn),
        .rdata    (reg_rdata_o),
        .clr_en   (clr_en),
        .clr_bits (clr_bits),
        .cmd_wr   (cmd_wr),
        .cmd_bits (cmd_bits)
    );

    assert_no_serr_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == '0) |=> !serr_o);

    assert_rsvd_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i == 3'd0) |-> (reg_rdata_o[DATA_W-1:STS_W] == '0 && reg_rdata_o[7:2] == '0));

endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_ce = 0, ev_ue = 0, ev_rf = 0, ev_lk = 0, ev_th = 0;
    logic [32:0] addr = '0;
    logic        chan = 0;
    logic [7:0]  syn = '0;
    logic [2:0]  sel = '0;
    logic        wr = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        serr;

    always #10 clk = ~clk;

    ecc_err_log u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_ce_i(ev_ce), .ev_ue_i(ev_ue), .ev_refresh_to_i(ev_rf),
        .ev_lock_i(ev_lk), .ev_thermal_i(ev_th),
        .err_addr_i(addr), .err_chan_i(chan), .err_syn_i(syn),
        .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .serr_o(serr)
    );

    // reference model state
    logic [15:0] m_sts = '0, m_cmd = '0;
    logic [32:0] m_addr = '0;
    logic        m_chan = 0, m_serr = 0;
    logic [7:0]  m_syn = '0;
    int n_chk = 0, n_bad = 0;
    int cycles = 0;
    string phase = "R10";
    localparam logic [15:0] ACT = 16'h0B03;

    function automatic logic [31:0] model_read(input logic [2:0] s);
        case (s)
            3'd0: return {16'h0, m_sts};
            3'd1: return {16'h0, m_cmd};
            3'd2: return {m_addr[31:7], 6'b0, m_chan};
            3'd3: return {31'b0, m_addr[32]};
            3'd4: return {24'h0, m_syn};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string field_req(input logic [2:0] s);
        case (s)
            3'd0: return "R1";
            3'd1: return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) sel=%0d actual=%h expected=%h", req, phase, sel, act, exp);
        end
    endtask

    // ev bits: 0 correctable, 1 uncorrectable, 2 refresh, 3 lock, 4 thermal
    task automatic step(input logic [4:0] ev, input logic [32:0] a, input logic c,
                        input logic [7:0] s, input logic [2:0] rs, input logic w,
                        input logic [31:0] d);
        logic [15:0] setm, clrm, nsts;
        @(negedge clk);
        {ev_th, ev_lk, ev_rf, ev_ue, ev_ce} = ev;
        addr = a; chan = c; syn = s; sel = rs; wr = w; wdata = d;
        #1;
        check(field_req(rs), rdata, model_read(rs));
        check("R9", {31'b0, serr}, {31'b0, m_serr});
        @(posedge clk);
        setm = {4'b0, ev[4], 1'b0, ev[3], ev[2], 6'b0, ev[1], ev[0]};
        clrm = (w && rs == 3'd0) ? (d[15:0] & ACT) : 16'h0;
        nsts = (m_sts & ~clrm) | setm;
        if ((ev[1] && !m_sts[1]) || (ev[0] && !m_sts[0] && !m_sts[1])) begin
            m_addr = a; m_chan = c; m_syn = s;
        end
        m_serr = |(nsts & ~m_sts & m_cmd);
        m_sts  = nsts;
        if (w && rs == 3'd1) m_cmd = d[15:0] & ACT;
    endtask

    task automatic peek(input logic [2:0] rs);
        step(5'b0, 33'h0, 1'b0, 8'h0, rs, 1'b0, 32'h0);
    endtask

    task automatic wreg(input logic [2:0] rs, input logic [31:0] d);
        step(5'b0, 33'h0, 1'b0, 8'h0, rs, 1'b1, d);
    endtask

    task automatic peek_all();
        for (int i = 0; i < 5; i++) peek(3'(i));
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        phase = "R10"; peek_all();

        phase = "R8"; wreg(3'd1, 32'hFFFF_FFFF); peek(3'd1);

        // first correctable error with address bit 32 set
        phase = "R4";
        step(5'b00001, 33'h1_2345_67FF, 1'b1, 8'h5A, 3'd0, 1'b0, 0);
        peek(3'd0); peek(3'd2); peek(3'd3); peek(3'd4);

        phase = "R5";
        step(5'b00001, 33'h0_0ABC_DE80, 1'b0, 8'h11, 3'd2, 1'b0, 0);
        peek(3'd2); peek(3'd4); peek(3'd3);

        phase = "R6";
        step(5'b00010, 33'h0_7777_7700, 1'b0, 8'hC3, 3'd0, 1'b0, 0);
        peek(3'd0); peek(3'd2); peek(3'd4); peek(3'd3);

        phase = "R7";
        step(5'b00010, 33'h1_FFFF_FF80, 1'b1, 8'h99, 3'd2, 1'b0, 0);
        peek(3'd2); peek(3'd4);
        step(5'b00010, 33'h1_1111_1100, 1'b1, 8'h44, 3'd0, 1'b1, 32'h2);
        peek(3'd2); peek(3'd0);
        step(5'b00001, 33'h0_2222_2200, 1'b1, 8'h55, 3'd2, 1'b0, 0);
        peek(3'd2);
        step(5'b00010, 33'h0_3333_3380, 1'b0, 8'h66, 3'd4, 1'b0, 0);
        peek(3'd2); peek(3'd4); peek(3'd0);

        phase = "R2";
        wreg(3'd0, 32'h0); peek(3'd0);
        wreg(3'd0, 32'h0000_0001); peek(3'd0);
        wreg(3'd0, 32'hFFFF_FFFF); peek(3'd0);

        phase = "R3";
        step(5'b00100, 33'h0, 1'b0, 8'h0, 3'd0, 1'b1, 32'h0100); peek(3'd0);
        step(5'b00100, 33'h0, 1'b0, 8'h0, 3'd0, 1'b1, 32'h0100); peek(3'd0);

        phase = "R1";
        step(5'b01000, 33'h0, 1'b0, 8'h0, 3'd0, 1'b0, 0); peek(3'd0);
        step(5'b10000, 33'h0, 1'b0, 8'h0, 3'd0, 1'b0, 0); peek(3'd0);

        phase = "R11";
        wreg(3'd2, 32'hFFFF_FFFF); wreg(3'd3, 32'hFFFF_FFFF); wreg(3'd4, 32'hFFFF_FFFF);
        peek(3'd2); peek(3'd3); peek(3'd4);

        phase = "R6";
        wreg(3'd0, 32'h0B03);
        step(5'b00011, 33'h0_ABCD_EF00, 1'b1, 8'hE7, 3'd0, 1'b0, 0);
        peek(3'd2); peek(3'd4); peek(3'd0);

        phase = "R9";
        wreg(3'd0, 32'h0B03);
        wreg(3'd1, 32'h0000_0800);
        step(5'b00001, 33'h0_0000_0080, 1'b0, 8'h01, 3'd0, 1'b0, 0); peek(3'd0);
        step(5'b10000, 33'h0, 1'b0, 8'h0, 3'd0, 1'b0, 0); peek(3'd0); peek(3'd0);
        wreg(3'd1, 32'h0);
        step(5'b00100, 33'h0, 1'b0, 8'h0, 3'd0, 1'b0, 0); peek(3'd0);

        phase = "RND";
        wreg(3'd1, 32'h0B03);
        for (int k = 0; k < 600; k++) begin
            logic [4:0] e;
            logic [2:0] r;
            logic       w;
            logic [31:0] d;
            e = 5'($urandom) & 5'($urandom) & 5'($urandom);
            r = 3'($urandom_range(0, 5));
            w = ($urandom_range(0, 5) == 0);
            d = $urandom;
            step(e, {1'($urandom), 32'($urandom)}, 1'($urandom), 8'($urandom), r, w, d);
        end
        peek_all();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule